// File: doc/BRIEF.md
# Conditional split-path pulsed register

This block is a cycle-level behavioural model of a pulse-triggered one-bit storage element. It runs on a fast sampling clock and treats the slower functional clock `ck` as an ordinary sampled input. Each falling edge of `ck` opens a short transparency window, and the window's timing is counted in sampling-clock ticks.

The output has two separate drive paths. The rise path can only set `q`. The fall path can only clear it. A delayed copy of the output, `qd`, picks which of the two paths is armed. When `qd` is 1, only the clearing path is armed. When `qd` is 0, only the setting path is armed. As a result, a strobe fires only when the data really differs from the stored value, and at most one strobe fires per window. Between windows, a keeper state holds `q`.

The window is built from four equal stages of `STAGE_TICKS` ticks each. The rise path is open for stages 0 to 2 after the edge is detected. The fall path is open for stages 1 to 3. `qd` trails `q` by `QD_LAG` ticks. `QD_LAG` should be at least `4*STAGE_TICKS`, so that a transition inside a window cannot switch the armed path.

Top module: `split_pulse_reg`

## Requirements
- R1: An active-high synchronous `rst` forces `q` and `qd` to 0 on the next clock edge, and no window is open after it.
- R2: A window opens only on a falling edge of `ck`: a high-to-low step between two consecutive samples. A rising edge never changes `q`.
- R3: When `qd` is 1, `q` becomes 0 one tick after any window tick in which the fall path is open and `d` is 0. The rise path stays inactive for that window.
- R4: When `qd` is 0, `q` becomes 1 one tick after any window tick in which the rise path is open and `d` is 1. The fall path stays inactive for that window.
- R5: When `d` equals the stored value during the whole window, no strobe fires and `q` is unchanged.
- R6: Outside a window, changes of `d` have no effect on `q`.
- R7: Count window ticks from 0, starting at the tick after the falling edge is sampled. The rise path is open for ticks 0 to 3*STAGE_TICKS-1. The fall path is open for ticks STAGE_TICKS to 4*STAGE_TICKS-1.
- R8: `qd` equals the value `q` had `QD_LAG` ticks earlier.
- R9: At most one strobe is active in any tick. An output transition inside a window cannot be followed by an opposite transition in the same window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ck | input | 1 | Functional clock, sampled |
| d | input | 1 | Data input |
| q | output | 1 | Stored output |
| qd | output | 1 | Delayed replica of `q` |

## Verification
The bench builds the block with `STAGE_TICKS` = 2 and `QD_LAG` = 9. The two-tick stages make the first stage, in which only the rise path is open, and the last stage, in which only the fall path is open, each span more than one tick. Directed data steps placed at exact window ticks can then show the rise path closing before the fall path. The lag of 9 ticks keeps `qd` flat across a whole 8-tick window. This exposes any design that selects the armed path from `q` itself, because such a design would re-fire after a clear. A behavioural reference model that shifts `q` through a queue is compared against both outputs on every tick.

// File: rtl/split_pulse_reg.sv
module split_pulse_reg #(
  parameter int STAGE_TICKS = 1,
  parameter int QD_LAG      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ck,
  input  logic d,
  output logic q,
  output logic qd
);
  localparam int SPAN = 4 * STAGE_TICKS;
  localparam int PW   = $clog2(SPAN + 1);

  logic          ck_d, busy;
  logic [PW-1:0] ph;
  logic [QD_LAG-1:0] lag;
  logic          ck_fall, rise_win, fall_win, set_s, clr_s;

  assign ck_fall  = ck_d & ~ck;
  assign rise_win = busy && (ph < PW'(3 * STAGE_TICKS));
  assign fall_win = busy && (ph >= PW'(STAGE_TICKS));
  assign set_s    = rise_win & ~qd & d;
  assign clr_s    = fall_win & qd & ~d;
  assign qd       = lag[QD_LAG-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_d <= 1'b0;
      busy <= 1'b0;
      ph   <= '0;
      q    <= 1'b0;
    end else begin
      ck_d <= ck;
      if (ck_fall) begin
        busy <= 1'b1;
        ph   <= '0;
      end else if (busy) begin
        if (ph == PW'(SPAN - 1)) busy <= 1'b0;
        else                     ph   <= ph + PW'(1);
      end
      if (set_s)      q <= 1'b1;
      else if (clr_s) q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lag <= '0;
    end else begin
      lag[0] <= q;
      for (int i = 1; i < QD_LAG; i++) lag[i] <= lag[i-1];
    end
  end
endmodule

// File: rtl/split_pulse_reg_chk.sv
module split_pulse_reg_chk (
  input logic clk,
  input logic rst,
  input logic d,
  input logic q,
  input logic qd,
  input logic set_s,
  input logic clr_s,
  input logic rise_win,
  input logic fall_win
);
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (!q && !qd));

  a_r3_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(q) |-> $past(qd && !d && fall_win));

  a_r4_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(q) |-> $past(!qd && d && rise_win));

  a_r6_hold_outside: assert property (@(posedge clk) disable iff (rst)
    !(rise_win || fall_win) |=> $stable(q));

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({set_s, clr_s}));

  a_r9_select_steady: assert property (@(posedge clk) disable iff (rst)
    ((rise_win || fall_win) && $past(rise_win || fall_win)) |-> $stable(qd));
endmodule

bind split_pulse_reg split_pulse_reg_chk u_chk (
  .clk(clk), .rst(rst), .d(d), .q(q), .qd(qd),
  .set_s(set_s), .clr_s(clr_s), .rise_win(rise_win), .fall_win(fall_win)
);

// File: tb/sim_split_pulse_reg.sv
`timescale 1ns/1ps
module sim_split_pulse_reg;
  localparam int S    = 2;
  localparam int LAG  = 9;
  localparam int SPAN = 4 * S;

  logic clk = 1'b0, rst = 1'b1, ck = 1'b0, d = 1'b0;
  logic q, qd;
  int checks = 0, errors = 0;
  bit started = 0;

  always #4 clk = ~clk;

  split_pulse_reg #(.STAGE_TICKS(S), .QD_LAG(LAG)) u0 (
    .clk(clk), .rst(rst), .ck(ck), .d(d), .q(q), .qd(qd));

  int mph = -1;
  bit mckd = 0, mq = 0;
  bit hist[$];

  always @(posedge clk) begin
    bit qn, nq;
    if (rst) begin
      mph = -1; mckd = 0; mq = 0;
      hist.delete();
      repeat (LAG) hist.push_back(1'b0);
      started = 1;
    end else begin
      qn = hist[0];
      nq = mq;
      if (mph >= 0 && mph < 3*S && !qn && d) nq = 1;
      if (mph >= S && mph < SPAN && qn && !d) nq = 0;
      if (mckd && !ck) mph = 0;
      else if (mph >= 0 && mph < SPAN-1) mph++;
      else mph = -1;
      mckd = ck;
      hist.push_back(mq);
      void'(hist.pop_front());
      mq = nq;
    end
  end

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    check("R7 q vs model", q, mq);
    check("R8 qd vs model", qd, hist[0]);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ck_high();
    ck = 1'b1;
    cyc(3);
  endtask

  initial begin
    cyc(3);
    check("R1 reset q", q, 1'b0);
    check("R1 reset qd", qd, 1'b0);
    rst = 1'b0;
    cyc(2);

    ck_high();
    d = 1'b1; ck = 1'b0;
    cyc(2);
    check("R4 set in first tick", q, 1'b1);
    check("R8 qd still old", qd, 1'b0);
    cyc(SPAN + LAG);
    check("R8 qd followed", qd, 1'b1);

    d = 1'b0; cyc(2);
    ck = 1'b1; cyc(5);
    check("R2 rising edge ignored", q, 1'b1);

    ck = 1'b0; cyc(1 + S);
    d = 1'b1;
    cyc(SPAN + LAG);
    check("R7 fall path shut in stage 0", q, 1'b1);
    ck_high();

    ck = 1'b0; cyc(1 + S);
    d = 1'b0; cyc(1);
    d = 1'b1;
    cyc(SPAN + LAG);
    check("R3 clear on d low", q, 1'b0);
    check("R9 no re-set in same window", qd, 1'b0);

    d = 1'b0; cyc(2); d = 1'b1; cyc(2); d = 1'b0; cyc(2); d = 1'b1; cyc(2);
    check("R6 d ignored outside window", q, 1'b0);
    ck = 1'b1; cyc(4);
    check("R2 rising edge with d high", q, 1'b0);

    d = 1'b0; ck = 1'b0; cyc(1 + 3*S);
    d = 1'b1;
    cyc(SPAN + LAG);
    check("R7 rise path shut after three stages", q, 1'b0);
    ck_high();

    d = 1'b0; ck = 1'b0; cyc(SPAN + LAG);
    check("R5 equal data low holds", q, 1'b0);
    ck_high();
    d = 1'b1; ck = 1'b0; cyc(SPAN + LAG);
    check("R4 set again", q, 1'b1);
    ck_high();
    ck = 1'b0; cyc(SPAN + LAG);
    check("R5 equal data high holds", q, 1'b1);

    rst = 1'b1; cyc(2);
    check("R1 mid-run reset q", q, 1'b0);
    check("R1 mid-run reset qd", qd, 1'b0);
    rst = 1'b0; cyc(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule